// File: doc/BRIEF.md
# Integer Register File with Architectural Aliases

This block holds the integer architectural state of a 64-bit core: a file of general entries with one combinational read port and one clocked write port, a small file of control registers, a 32-bit status word and a program counter. Several named registers have no storage of their own. They live inside fixed general entries or inside bit fields of the status word, and each gets a dedicated port so that execution units can reach it without going through the general port.

The general port offers two views: a full-width view and a 32-bit compatibility view that reads the low half and sign-extends on write. The last entry is a hardwired zero. Control register 0 is a window onto the status word. A program-counter write peels bit 0 off into an instruction-set mode flag, which has no write path of its own. All writes commit on the rising clock edge. Reads see the state held before that edge.

Top module: `rfa_regfile`

## Requirements
- R1: After reset every general entry, every control register, the status word, the PC and the mode flag read as zero.
- R2: Entry NREG-1 (63) always reads as zero, and a general write to it is discarded.
- R3: A full-width general write is visible on the read port from the next cycle on. A read of the same entry in the same cycle as the write returns the old value.
- R4: With `rd_narrow`=1 the read returns bits 31:0 of the entry, with bits 63:32 zero. With `wr_narrow`=1 the write stores `wr_data[31:0]` sign-extended from bit 31.
- R5: Control index 0 reads as the 32-bit status word zero-extended, and a write to index 0 stores `cr_wr_data[31:0]` into the status word. Other control indices keep their own 64-bit value.
- R6: Entry 17 is the multiply-accumulate pair: `mac_hi` is bits 63:32 and `mac_lo` is bits 31:0. Writing one half leaves the other half unchanged.
- R7: `tflag` is bit 0 of entry 19, and a write through `t_we` changes only that bit.
- R8: `alias_sel` 0 selects entry 16, 1 selects entry 18 and 2 selects entry 20. `gbr`, `pr` and `vbr` show bits 31:0 of these entries. An alias write stores `alias_wdata` sign-extended, and `alias_sel`=3 writes nothing.
- R9: A PC write stores `pc_wdata[0]` into `isa_mode` and stores `pc_wdata` with bit 0 cleared into `pc`. `isa_mode` changes only on a PC write.
- R10: `sr_flags[0]`, `sr_flags[1]` and `sr_flags[2]` are status bits 1, 8 and 9. A write through `flag_we[i]` changes only that bit.
- R11: When a dedicated port writes the same entry or status word as the general or control port in the same cycle, the dedicated field lands on top of the general write, and the rest of the general write is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_idx | input | 6 | General read index |
| rd_narrow | input | 1 | Select the 32-bit read view |
| rd_data | output | 64 | General read data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 6 | General write index |
| wr_narrow | input | 1 | Select the 32-bit sign-extending write view |
| wr_data | input | 64 | General write data |
| cr_rd_idx | input | 3 | Control register read index |
| cr_rd_data | output | 64 | Control register read data |
| cr_wr_en | input | 1 | Control register write enable |
| cr_wr_idx | input | 3 | Control register write index |
| cr_wr_data | input | 64 | Control register write data |
| flag_we | input | 3 | Per-flag write enables (0 S, 1 Q, 2 M) |
| flag_wdata | input | 3 | Per-flag write values |
| sr_flags | output | 3 | Status flags (0 S, 1 Q, 2 M) |
| mac_hi_we | input | 1 | Write enable, upper accumulator half |
| mac_hi_wdata | input | 32 | Upper accumulator half value |
| mac_lo_we | input | 1 | Write enable, lower accumulator half |
| mac_lo_wdata | input | 32 | Lower accumulator half value |
| mac_hi | output | 32 | Upper accumulator half |
| mac_lo | output | 32 | Lower accumulator half |
| t_we | input | 1 | T flag write enable |
| t_wdata | input | 1 | T flag value |
| tflag | output | 1 | T flag |
| alias_we | input | 1 | Named-pointer write enable |
| alias_sel | input | 2 | Named-pointer select |
| alias_wdata | input | 32 | Named-pointer value |
| gbr | output | 32 | Global base pointer view |
| pr | output | 32 | Procedure return view |
| vbr | output | 32 | Vector base view |
| pc_we | input | 1 | PC write enable |
| pc_wdata | input | 64 | PC write value with mode in bit 0 |
| pc | output | 64 | Program counter |
| isa_mode | output | 1 | Instruction-set mode flag |

## Verification
The bench builds the block with its defaults: 64 entries of 64 bits, eight control registers and a 32-bit status word. With these values the zero entry sits at index 63, and the alias entries 16 to 20 and status bits 1, 8 and 9 all exist. Every corner listed above can therefore be reached with direct writes and reads. The directed scenarios include same-cycle collisions on entry 17 and on the status word, which exercise the overlay order.

// File: rtl/rfa_pkg.sv
package rfa_pkg;

    // Fixed entries that carry named registers
    localparam int GBR_ENTRY  = 16;
    localparam int MAC_ENTRY  = 17;
    localparam int PR_ENTRY   = 18;
    localparam int T_ENTRY    = 19;
    localparam int VBR_ENTRY  = 20;

    // Status word flag positions, index 0 S, 1 Q, 2 M
    localparam int NFLAG = 3;
    localparam int FLAG_POS [NFLAG] = '{1, 8, 9};

    typedef enum logic [1:0] {
        SEL_GBR  = 2'd0,
        SEL_PR   = 2'd1,
        SEL_VBR  = 2'd2,
        SEL_NONE = 2'd3
    } alias_sel_e;

endpackage

// File: rtl/rfa_gpr_bank.sv
module rfa_gpr_bank #(
    parameter int XLEN = 64,
    parameter int NREG = 64,
    localparam int HALF = XLEN / 2,
    localparam int IW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   rd_idx,
    input  logic            rd_narrow,
    output logic [XLEN-1:0] rd_data,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic            wr_narrow,
    input  logic [XLEN-1:0] wr_data,
    input  logic            mac_hi_we,
    input  logic [HALF-1:0] mac_hi_wdata,
    input  logic            mac_lo_we,
    input  logic [HALF-1:0] mac_lo_wdata,
    output logic [HALF-1:0] mac_hi,
    output logic [HALF-1:0] mac_lo,
    input  logic            t_we,
    input  logic            t_wdata,
    output logic            tflag,
    input  logic            alias_we,
    input  logic [1:0]      alias_sel,
    input  logic [HALF-1:0] alias_wdata,
    output logic [HALF-1:0] gbr,
    output logic [HALF-1:0] pr,
    output logic [HALF-1:0] vbr
);
    import rfa_pkg::*;

    localparam logic [IW-1:0] ZERO_I = IW'(NREG - 1);
    localparam logic [IW-1:0] GBR_I  = IW'(GBR_ENTRY);
    localparam logic [IW-1:0] MAC_I  = IW'(MAC_ENTRY);
    localparam logic [IW-1:0] PR_I   = IW'(PR_ENTRY);
    localparam logic [IW-1:0] T_I    = IW'(T_ENTRY);
    localparam logic [IW-1:0] VBR_I  = IW'(VBR_ENTRY);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] ent;
    } bank_t;

    bank_t s_d, s_q;

    function automatic logic [XLEN-1:0] sext_half(input logic [HALF-1:0] v);
        return {{(XLEN-HALF){v[HALF-1]}}, v};
    endfunction

    always_comb begin
        s_d = s_q;
        // general port first; dedicated ports overlay it
        if (wr_en && (wr_idx != ZERO_I)) begin
            s_d.ent[wr_idx] = wr_narrow ? sext_half(wr_data[HALF-1:0]) : wr_data;
        end
        if (alias_we) begin
            case (alias_sel_e'(alias_sel))
                SEL_GBR: s_d.ent[GBR_I] = sext_half(alias_wdata);
                SEL_PR:  s_d.ent[PR_I]  = sext_half(alias_wdata);
                SEL_VBR: s_d.ent[VBR_I] = sext_half(alias_wdata);
                default: ;
            endcase
        end
        if (mac_hi_we) s_d.ent[MAC_I][XLEN-1:HALF] = mac_hi_wdata;
        if (mac_lo_we) s_d.ent[MAC_I][HALF-1:0]    = mac_lo_wdata;
        if (t_we)      s_d.ent[T_I][0]             = t_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic [XLEN-1:0] rd_entry;
    always_comb begin
        rd_entry = (rd_idx == ZERO_I) ? '0 : s_q.ent[rd_idx];
        rd_data  = rd_narrow ? {{(XLEN-HALF){1'b0}}, rd_entry[HALF-1:0]} : rd_entry;
    end

    assign mac_hi = s_q.ent[MAC_I][XLEN-1:HALF];
    assign mac_lo = s_q.ent[MAC_I][HALF-1:0];
    assign tflag  = s_q.ent[T_I][0];
    assign gbr    = s_q.ent[GBR_I][HALF-1:0];
    assign pr     = s_q.ent[PR_I][HALF-1:0];
    assign vbr    = s_q.ent[VBR_I][HALF-1:0];

endmodule

// File: rtl/rfa_ctrl_bank.sv
module rfa_ctrl_bank #(
    parameter int XLEN = 64,
    parameter int NCR  = 8,
    parameter int SRW  = 32,
    localparam int CW    = $clog2(NCR),
    localparam int NFLAG = rfa_pkg::NFLAG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cr_rd_idx,
    output logic [XLEN-1:0]  cr_rd_data,
    input  logic             cr_wr_en,
    input  logic [CW-1:0]    cr_wr_idx,
    input  logic [XLEN-1:0]  cr_wr_data,
    input  logic [NFLAG-1:0] flag_we,
    input  logic [NFLAG-1:0] flag_wdata,
    output logic [NFLAG-1:0] sr_flags
);
    import rfa_pkg::*;

    typedef struct packed {
        logic [NCR-1:0][XLEN-1:0] cr;
        logic [SRW-1:0]           sr;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cr_wr_en) begin
            if (cr_wr_idx == '0) s_d.sr = cr_wr_data[SRW-1:0];
            else                 s_d.cr[cr_wr_idx] = cr_wr_data;
        end
        // single-bit flag writes overlay a whole-word write
        for (int i = 0; i < NFLAG; i++) begin
            if (flag_we[i]) s_d.sr[FLAG_POS[i]] = flag_wdata[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cr_rd_data = (cr_rd_idx == '0) ? {{(XLEN-SRW){1'b0}}, s_q.sr}
                                          : s_q.cr[cr_rd_idx];

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        assign sr_flags[g] = s_q.sr[FLAG_POS[g]];
    end

endmodule

// File: rtl/rfa_pc_unit.sv
module rfa_pc_unit #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_we,
    input  logic [XLEN-1:0] pc_wdata,
    output logic [XLEN-1:0] pc,
    output logic            isa_mode
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            mode;
    } pc_t;

    pc_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pc_we) begin
            s_d.mode = pc_wdata[0];
            s_d.pc   = {pc_wdata[XLEN-1:1], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pc       = s_q.pc;
    assign isa_mode = s_q.mode;

endmodule

// File: rtl/rfa_regfile.sv
module rfa_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 64,
    parameter int NCR  = 8,
    parameter int SRW  = 32,
    localparam int HALF  = XLEN / 2,
    localparam int IW    = $clog2(NREG),
    localparam int CW    = $clog2(NCR),
    localparam int NFLAG = rfa_pkg::NFLAG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    rd_idx,
    input  logic             rd_narrow,
    output logic [XLEN-1:0]  rd_data,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic             wr_narrow,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [CW-1:0]    cr_rd_idx,
    output logic [XLEN-1:0]  cr_rd_data,
    input  logic             cr_wr_en,
    input  logic [CW-1:0]    cr_wr_idx,
    input  logic [XLEN-1:0]  cr_wr_data,
    input  logic [NFLAG-1:0] flag_we,
    input  logic [NFLAG-1:0] flag_wdata,
    output logic [NFLAG-1:0] sr_flags,
    input  logic             mac_hi_we,
    input  logic [HALF-1:0]  mac_hi_wdata,
    input  logic             mac_lo_we,
    input  logic [HALF-1:0]  mac_lo_wdata,
    output logic [HALF-1:0]  mac_hi,
    output logic [HALF-1:0]  mac_lo,
    input  logic             t_we,
    input  logic             t_wdata,
    output logic             tflag,
    input  logic             alias_we,
    input  logic [1:0]       alias_sel,
    input  logic [HALF-1:0]  alias_wdata,
    output logic [HALF-1:0]  gbr,
    output logic [HALF-1:0]  pr,
    output logic [HALF-1:0]  vbr,
    input  logic             pc_we,
    input  logic [XLEN-1:0]  pc_wdata,
    output logic [XLEN-1:0]  pc,
    output logic             isa_mode
);

    rfa_gpr_bank #(.XLEN(XLEN), .NREG(NREG)) u_gpr (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_idx       (rd_idx),
        .rd_narrow    (rd_narrow),
        .rd_data      (rd_data),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_narrow    (wr_narrow),
        .wr_data      (wr_data),
        .mac_hi_we    (mac_hi_we),
        .mac_hi_wdata (mac_hi_wdata),
        .mac_lo_we    (mac_lo_we),
        .mac_lo_wdata (mac_lo_wdata),
        .mac_hi       (mac_hi),
        .mac_lo       (mac_lo),
        .t_we         (t_we),
        .t_wdata      (t_wdata),
        .tflag        (tflag),
        .alias_we     (alias_we),
        .alias_sel    (alias_sel),
        .alias_wdata  (alias_wdata),
        .gbr          (gbr),
        .pr           (pr),
        .vbr          (vbr)
    );

    rfa_ctrl_bank #(.XLEN(XLEN), .NCR(NCR), .SRW(SRW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cr_rd_idx  (cr_rd_idx),
        .cr_rd_data (cr_rd_data),
        .cr_wr_en   (cr_wr_en),
        .cr_wr_idx  (cr_wr_idx),
        .cr_wr_data (cr_wr_data),
        .flag_we    (flag_we),
        .flag_wdata (flag_wdata),
        .sr_flags   (sr_flags)
    );

    rfa_pc_unit #(.XLEN(XLEN)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc_we    (pc_we),
        .pc_wdata (pc_wdata),
        .pc       (pc),
        .isa_mode (isa_mode)
    );

endmodule

// File: rtl/rfa_regfile_chk.sv
module rfa_regfile_chk #(
    parameter int XLEN = 64,
    parameter int NREG = 64,
    parameter int NCR  = 8,
    parameter int SRW  = 32,
    localparam int HALF  = XLEN / 2,
    localparam int IW    = $clog2(NREG),
    localparam int CW    = $clog2(NCR),
    localparam int NFLAG = rfa_pkg::NFLAG
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IW-1:0]    rd_idx,
    input logic             rd_narrow,
    input logic [XLEN-1:0]  rd_data,
    input logic             wr_en,
    input logic [IW-1:0]    wr_idx,
    input logic [CW-1:0]    cr_rd_idx,
    input logic [XLEN-1:0]  cr_rd_data,
    input logic [NFLAG-1:0] flag_we,
    input logic [NFLAG-1:0] flag_wdata,
    input logic [NFLAG-1:0] sr_flags,
    input logic             mac_hi_we,
    input logic             mac_lo_we,
    input logic [HALF-1:0]  mac_lo,
    input logic             t_we,
    input logic             t_wdata,
    input logic             tflag,
    input logic             alias_we,
    input logic [1:0]       alias_sel,
    input logic [HALF-1:0]  alias_wdata,
    input logic [HALF-1:0]  gbr,
    input logic             pc_we,
    input logic [XLEN-1:0]  pc_wdata,
    input logic [XLEN-1:0]  pc,
    input logic             isa_mode
);
    localparam logic [IW-1:0] ZERO_I = IW'(NREG - 1);
    localparam logic [IW-1:0] MAC_I  = IW'(rfa_pkg::MAC_ENTRY);

    p_zero_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == ZERO_I) |-> (rd_data == '0));

    p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_narrow |-> (rd_data[XLEN-1:HALF] == '0));

    p_sr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_rd_idx == '0) |-> (cr_rd_data[XLEN-1:SRW] == '0));

    p_mac_lo_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_hi_we && !mac_lo_we && !(wr_en && wr_idx == MAC_I)) |=> (mac_lo == $past(mac_lo)));

    p_tflag_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        t_we |=> (tflag == $past(t_wdata)));

    p_gbr_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alias_we && alias_sel == 2'd0) |=> (gbr == $past(alias_wdata)));

    p_pc_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> ((pc == {$past(pc_wdata[XLEN-1:1]), 1'b0}) && (isa_mode == $past(pc_wdata[0]))));

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> $stable(isa_mode));

    p_flag_s_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we[0] |=> (sr_flags[0] == $past(flag_wdata[0])));

endmodule

bind rfa_regfile rfa_regfile_chk #(.XLEN(XLEN), .NREG(NREG), .NCR(NCR), .SRW(SRW)) u_chk (.*);

// File: tb/rfa_regfile_test.sv
`timescale 1ns/1ps
module rfa_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic        rd_narrow = 1'b0;
    logic [63:0] rd_data;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic        wr_narrow = 1'b0;
    logic [63:0] wr_data = '0;
    logic [2:0]  cr_rd_idx = '0;
    logic [63:0] cr_rd_data;
    logic        cr_wr_en = 1'b0;
    logic [2:0]  cr_wr_idx = '0;
    logic [63:0] cr_wr_data = '0;
    logic [2:0]  flag_we = '0;
    logic [2:0]  flag_wdata = '0;
    logic [2:0]  sr_flags;
    logic        mac_hi_we = 1'b0;
    logic [31:0] mac_hi_wdata = '0;
    logic        mac_lo_we = 1'b0;
    logic [31:0] mac_lo_wdata = '0;
    logic [31:0] mac_hi, mac_lo;
    logic        t_we = 1'b0;
    logic        t_wdata = 1'b0;
    logic        tflag;
    logic        alias_we = 1'b0;
    logic [1:0]  alias_sel = '0;
    logic [31:0] alias_wdata = '0;
    logic [31:0] gbr, pr, vbr;
    logic        pc_we = 1'b0;
    logic [63:0] pc_wdata = '0;
    logic [63:0] pc;
    logic        isa_mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rfa_regfile uut (.*);

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        wr_en = 0; cr_wr_en = 0; flag_we = '0; mac_hi_we = 0; mac_lo_we = 0;
        t_we = 0; alias_we = 0; pc_we = 0; wr_narrow = 0;
    endtask

    // returns after the edge that committed whatever was driven
    task automatic commit();
        @(negedge clk);
        quiet();
    endtask

    task automatic gwrite(input logic [5:0] idx, input logic narrow, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = idx; wr_narrow = narrow; wr_data = d;
        commit();
    endtask

    task automatic gread(input logic [5:0] idx, input logic narrow, output logic [63:0] d);
        rd_idx = idx; rd_narrow = narrow;
        #1 d = rd_data;
        rd_narrow = 0;
    endtask

    task automatic crread(input logic [2:0] idx, output logic [63:0] d);
        cr_rd_idx = idx;
        #1 d = cr_rd_data;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        gread(6'd0, 0, v);  check("R1", "entry 0", v, 64'h0);
        gread(6'd17, 0, v); check("R1", "entry 17", v, 64'h0);
        crread(3'd0, v);    check("R1", "status word", v, 64'h0);
        crread(3'd5, v);    check("R1", "cr 5", v, 64'h0);
        check("R1", "pc", pc, 64'h0);
        check("R1", "mode", {63'h0, isa_mode}, 64'h0);
    endtask

    task automatic t_basic_rw();
        logic [63:0] v;
        @(negedge clk);
        wr_en = 1; wr_idx = 6'd5; wr_data = 64'h1122_3344_5566_7788;
        gread(6'd5, 0, v); check("R3", "same-cycle read old", v, 64'h0);
        commit();
        gread(6'd5, 0, v); check("R3", "read after write", v, 64'h1122_3344_5566_7788);
        gwrite(6'd0, 0, 64'hFEDC_BA98_7654_3210);
        gread(6'd0, 0, v); check("R3", "entry 0 write", v, 64'hFEDC_BA98_7654_3210);
    endtask

    task automatic t_zero();
        logic [63:0] v;
        gwrite(6'd63, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        gread(6'd63, 0, v); check("R2", "zero entry full", v, 64'h0);
        gread(6'd63, 1, v); check("R2", "zero entry narrow", v, 64'h0);
    endtask

    task automatic t_narrow();
        logic [63:0] v;
        gwrite(6'd7, 0, 64'hAAAA_BBBB_8000_0001);
        gread(6'd7, 1, v); check("R4", "narrow read", v, 64'h0000_0000_8000_0001);
        gwrite(6'd8, 1, 64'h1234_5678_8000_0000);
        gread(6'd8, 0, v); check("R4", "narrow write neg", v, 64'hFFFF_FFFF_8000_0000);
        gwrite(6'd8, 1, 64'hFFFF_FFFF_7000_0000);
        gread(6'd8, 0, v); check("R4", "narrow write pos", v, 64'h0000_0000_7000_0000);
    endtask

    task automatic t_ctrl();
        logic [63:0] v;
        @(negedge clk);
        cr_wr_en = 1; cr_wr_idx = 3'd0; cr_wr_data = 64'hDEAD_BEEF_0000_0302;
        commit();
        crread(3'd0, v); check("R5", "status via cr0", v, 64'h0000_0000_0000_0302);
        check("R10", "flags from word", {61'h0, sr_flags}, 64'h7);
        @(negedge clk);
        cr_wr_en = 1; cr_wr_idx = 3'd3; cr_wr_data = 64'hCAFE_F00D_1234_5678;
        commit();
        crread(3'd3, v); check("R5", "cr3 full width", v, 64'hCAFE_F00D_1234_5678);
        crread(3'd0, v); check("R5", "status kept", v, 64'h302);
    endtask

    task automatic t_flags();
        logic [63:0] v;
        @(negedge clk);
        flag_we = 3'b001; flag_wdata = 3'b000;
        commit();
        crread(3'd0, v); check("R10", "clear S", v, 64'h300);
        @(negedge clk);
        flag_we = 3'b100; flag_wdata = 3'b000;
        commit();
        crread(3'd0, v); check("R10", "clear M", v, 64'h100);
        check("R10", "flag vector", {61'h0, sr_flags}, 64'h2);
    endtask

    task automatic t_mac();
        logic [63:0] v;
        @(negedge clk);
        mac_hi_we = 1; mac_hi_wdata = 32'h1111_2222;
        commit();
        gread(6'd17, 0, v); check("R6", "hi write", v, 64'h1111_2222_0000_0000);
        @(negedge clk);
        mac_lo_we = 1; mac_lo_wdata = 32'h3333_4444;
        commit();
        gread(6'd17, 0, v); check("R6", "lo write keeps hi", v, 64'h1111_2222_3333_4444);
        check("R6", "mac ports", {mac_hi, mac_lo}, 64'h1111_2222_3333_4444);
    endtask

    task automatic t_tbit();
        logic [63:0] v;
        gwrite(6'd19, 0, 64'hFFFF_FFFF_FFFF_FFFE);
        check("R7", "tflag from entry", {63'h0, tflag}, 64'h0);
        @(negedge clk);
        t_we = 1; t_wdata = 1;
        commit();
        gread(6'd19, 0, v); check("R7", "set T", v, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        t_we = 1; t_wdata = 0;
        commit();
        gread(6'd19, 0, v); check("R7", "clear T", v, 64'hFFFF_FFFF_FFFF_FFFE);
    endtask

    task automatic t_alias();
        logic [63:0] v;
        @(negedge clk);
        alias_we = 1; alias_sel = 2'd0; alias_wdata = 32'h8000_0000;
        commit();
        gread(6'd16, 0, v); check("R8", "gbr entry sext", v, 64'hFFFF_FFFF_8000_0000);
        @(negedge clk);
        alias_we = 1; alias_sel = 2'd1; alias_wdata = 32'h0000_0001;
        commit();
        gread(6'd18, 0, v); check("R8", "pr entry", v, 64'h1);
        @(negedge clk);
        alias_we = 1; alias_sel = 2'd2; alias_wdata = 32'h7FFF_FFFF;
        commit();
        gread(6'd20, 0, v); check("R8", "vbr entry", v, 64'h7FFF_FFFF);
        @(negedge clk);
        alias_we = 1; alias_sel = 2'd3; alias_wdata = 32'h5A5A_5A5A;
        commit();
        check("R8", "sel 3 no write gbr", {32'h0, gbr}, 64'h8000_0000);
        check("R8", "sel 3 no write pr", {32'h0, pr}, 64'h1);
        check("R8", "sel 3 no write vbr", {32'h0, vbr}, 64'h7FFF_FFFF);
    endtask

    task automatic t_pc();
        @(negedge clk);
        pc_we = 1; pc_wdata = 64'h0000_0000_1000_0001;
        commit();
        check("R9", "pc odd write", pc, 64'h1000_0000);
        check("R9", "mode set", {63'h0, isa_mode}, 64'h1);
        repeat (2) @(negedge clk);
        check("R9", "mode holds", {63'h0, isa_mode}, 64'h1);
        @(negedge clk);
        pc_we = 1; pc_wdata = 64'h0000_0000_2000_0002;
        commit();
        check("R9", "pc even write", pc, 64'h2000_0002);
        check("R9", "mode clear", {63'h0, isa_mode}, 64'h0);
    endtask

    task automatic t_overlay();
        logic [63:0] v;
        @(negedge clk);
        wr_en = 1; wr_idx = 6'd17; wr_data = 64'hAAAA_AAAA_AAAA_AAAA;
        mac_lo_we = 1; mac_lo_wdata = 32'h5555_5555;
        commit();
        gread(6'd17, 0, v); check("R11", "general plus mac lo", v, 64'hAAAA_AAAA_5555_5555);
        @(negedge clk);
        cr_wr_en = 1; cr_wr_idx = 3'd0; cr_wr_data = 64'h0000_0000_0000_0202;
        flag_we = 3'b010; flag_wdata = 3'b010;
        commit();
        crread(3'd0, v); check("R11", "status word plus Q", v, 64'h302);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic_rw();
        t_zero();
        t_narrow();
        t_ctrl();
        t_flags();
        t_mac();
        t_tbit();
        t_alias();
        t_pc();
        t_overlay();
        done = 1;
        summary();
    end

endmodule